// File: doc/BRIEF.md
# Set-Associative Tag Directory with MESI State

This block holds the tags and coherence states of an eight-way, sixty-four-set cache with 64-byte lines. It performs the hit check for each access. A lookup is split across two cycles so that it can overlap address translation. In the first cycle the set is picked from the untranslated virtual address. In the second cycle the physical page number arrives from translation and is compared against all eight ways of that set in parallel. The block returns hit or miss, the matching way and the line's state. On a miss it raises a request toward the next cache level.

The same directory accepts maintenance operations, one per cycle. A fill picks a victim way and writes a new tag and state. When the victim holds dirty data, the fill reports that a writeback is needed, together with the old tag. A set-state operation rewrites the state of one addressed way. An invalidate clears one addressed way. Victims are chosen first among empty ways, and otherwise by a per-set tree pseudo-LRU. When the block is used for instructions, a parameter limits every stored state to Invalid or Shared.

The lookup sequencer has two states. `LK_IDLE` means no comparison is due. `LK_CMP` means a comparison is due this cycle. The transitions are `LK_IDLE -> LK_CMP` and `LK_CMP -> LK_CMP`, taken when a lookup is presented, and `LK_CMP -> LK_IDLE` and `LK_IDLE -> LK_IDLE`, taken when none is presented.

Top module: `tagdir_top`

## Requirements
- R1: Reset sets every entry to Invalid (state code 2'b00) and every replacement tree to all zeros. After reset, every lookup misses and a fill into any set lands in way 0.
- R2: The set index is virtual address bits 11:6. Bits 5:0 (the line offset) and all bits above bit 11 have no effect on the result.
- R3: A lookup presented with `lk_valid` in cycle N produces `res_valid` in cycle N+1. The result is computed from the `lk_ptag` presented in cycle N+1. A new lookup may be presented in cycle N+1 while the previous one is being compared.
- R4: A hit requires a stored tag equal to `lk_ptag` in a way whose state is not Invalid. The state codes are Shared 2'b01, Exclusive 2'b10 and Modified 2'b11. On a hit, `res_way` is the lowest-numbered matching way and `res_state` is its state.
- R5: On a miss, `miss_req` is 1 and `miss_line` is {`lk_ptag`, set index}, while `res_way` and `res_state` read 0. `miss_req` is 0 whenever `res_valid` is 0 or `res_hit` is 1.
- R6: A fill is `op_valid` with `op_kind` 2'b00. It writes `op_tag` and `op_state` into the lowest-numbered Invalid way of `op_set` when one exists, and it reports that way on `fill_way` in the same cycle.
- R7: When no way of the set is Invalid, the fill victim comes from a 7-bit tree. Node 0 chooses between ways 0-3 and ways 4-7. Node 1 splits ways 0-3 and node 2 splits ways 4-7. Nodes 3 to 6 split the pairs (0,1), (2,3), (4,5) and (6,7). A node value of 1 selects the upper side. Every hit and every fill sets the nodes on the accessed way's path to point away from that way; when both happen in one set in one cycle, the fill is applied last.
- R8: When a fill's victim is Modified, `wb_valid` is 1 in the fill cycle and `wb_tag` carries the victim's old tag. `wb_valid` is 0 in every other cycle.
- R9: `op_kind` 2'b01 writes `op_state` into way `op_way` of `op_set`. `op_kind` 2'b10 writes Invalid there. `op_kind` 2'b11 changes nothing.
- R10: An operation on the set being compared in the same cycle takes effect before the comparison. The lookup result reflects the written tag and state.
- R11: With `ICACHE` set, a requested Exclusive or Modified state is stored as Shared. With `ICACHE` clear, states are stored as given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup presented (first stage) |
| lk_vaddr | input | 32 | Virtual address of the lookup (first stage) |
| lk_ptag | input | 24 | Physical page number (second stage) |
| op_valid | input | 1 | Maintenance operation presented |
| op_kind | input | 2 | 00 fill, 01 set state, 10 invalidate, 11 none |
| op_set | input | 6 | Target set of the operation |
| op_way | input | 3 | Target way for set-state and invalidate |
| op_tag | input | 24 | Tag written by a fill |
| op_state | input | 2 | State written by a fill or set-state |
| res_valid | output | 1 | Comparison result present |
| res_hit | output | 1 | Lookup hit |
| res_way | output | 3 | Matching way |
| res_state | output | 2 | State of the matching line |
| miss_req | output | 1 | Request to the next level |
| miss_line | output | 30 | Line address of the miss |
| fill_way | output | 3 | Way chosen by a fill |
| wb_valid | output | 1 | Fill evicts a Modified line |
| wb_tag | output | 24 | Tag of the evicted line |

## Verification
The assertions check several properties on every cycle. A result never appears without a lookup one cycle earlier. A hit never reports Invalid, and exactly one of hit or miss accompanies each result. A writeback flag occurs only with a fill, and a fill never skips a free way. Every directory write is visible in the following cycle, and in instruction mode no stored state above Shared reaches the result.

Some behaviours only the bench scenarios can show. These are the exact victim order produced by the replacement tree, writeback of the correct old tag, the effect of same-cycle operations on the comparison, and back-to-back lookups. The bench shows them by comparing every result against a directory model under random traffic confined to a few sets.

// File: rtl/tagdir_pkg.sv
package tagdir_pkg;

    typedef enum logic [1:0] {
        MESI_I = 2'b00,
        MESI_S = 2'b01,
        MESI_E = 2'b10,
        MESI_M = 2'b11
    } mesi_e;

    typedef enum logic [1:0] {
        OP_FILL  = 2'b00,
        OP_SETST = 2'b01,
        OP_INVAL = 2'b10,
        OP_NONE  = 2'b11
    } opk_e;

    typedef enum logic {
        LK_IDLE = 1'b0,
        LK_CMP  = 1'b1
    } lk_state_e;

endpackage

// File: rtl/tagdir_store.sv
module tagdir_store
    import tagdir_pkg::*;
#(
    parameter int SETS  = 64,
    parameter int WAYS  = 8,
    parameter int TAG_W = 24
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(SETS)-1:0]  wr_set,
    input  logic [$clog2(WAYS)-1:0]  wr_way,
    input  logic                     wr_tag_en,
    input  logic [TAG_W-1:0]         wr_tag,
    input  logic [1:0]               wr_state,
    input  logic [$clog2(SETS)-1:0]  a_set,
    output logic [TAG_W-1:0]         a_tag [WAYS],
    output logic [1:0]               a_st  [WAYS],
    input  logic [$clog2(SETS)-1:0]  b_set,
    output logic [TAG_W-1:0]         b_tag [WAYS],
    output logic [1:0]               b_st  [WAYS]
);
    localparam int IDX_W = $clog2(SETS);
    localparam int WW    = $clog2(WAYS);

    logic [TAG_W-1:0] tag_q [SETS][WAYS];
    logic [1:0]       st_q  [SETS][WAYS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    st_q[s][w] <= MESI_I;
        end else if (we) begin
            st_q[wr_set][wr_way] <= wr_state;
        end
    end

    always_ff @(posedge clk) begin
        if (we && wr_tag_en)
            tag_q[wr_set][wr_way] <= wr_tag;
    end

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            a_tag[w] = tag_q[a_set][w];
            a_st[w]  = st_q[a_set][w];
            b_tag[w] = tag_q[b_set][w];
            b_st[w]  = st_q[b_set][w];
        end
    end

    // Last write, held one cycle to check it landed
    logic             chk_v;
    logic [IDX_W-1:0] chk_set;
    logic [WW-1:0]    chk_way;
    logic [1:0]       chk_st;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_v   <= 1'b0;
            chk_set <= '0;
            chk_way <= '0;
            chk_st  <= MESI_I;
        end else begin
            chk_v   <= we;
            chk_set <= wr_set;
            chk_way <= wr_way;
            chk_st  <= wr_state;
        end
    end

    // R9: a directory write is visible in the next cycle
    a_r9_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        chk_v |-> st_q[chk_set][chk_way] == chk_st);

endmodule

// File: rtl/tagdir_plru.sv
module tagdir_plru #(
    parameter int SETS = 64,
    parameter int WAYS = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     hit_we,
    input  logic [$clog2(SETS)-1:0]  hit_set,
    input  logic [$clog2(WAYS)-1:0]  hit_way,
    input  logic                     fill_we,
    input  logic [$clog2(SETS)-1:0]  fill_set,
    input  logic [$clog2(WAYS)-1:0]  fill_way,
    input  logic [$clog2(SETS)-1:0]  v_set,
    output logic [$clog2(WAYS)-1:0]  v_way
);
    localparam int IDX_W = $clog2(SETS);
    localparam int LVL   = $clog2(WAYS);
    localparam int NB    = WAYS - 1;

    logic [NB-1:0] tree_q [SETS];
    logic [NB-1:0] tree_d [SETS];

    // Point every node on the path away from way w
    function automatic logic [NB-1:0] touch(logic [NB-1:0] t, logic [LVL-1:0] w);
        int  n;
        logic d;
        n = 0;
        for (int l = 0; l < LVL; l++) begin
            d = w[LVL-1-l];
            t[n[LVL-1:0]] = ~d;
            n = 2 * n + 1 + int'(d);
        end
        return t;
    endfunction

    function automatic logic [LVL-1:0] walk(logic [NB-1:0] t);
        int  n;
        n = 0;
        for (int l = 0; l < LVL; l++)
            n = 2 * n + 1 + int'(t[n[LVL-1:0]]);
        return LVL'(n - NB);
    endfunction

    always_comb begin
        for (int s = 0; s < SETS; s++) begin
            tree_d[s] = tree_q[s];
            if (hit_we && hit_set == IDX_W'(s))
                tree_d[s] = touch(tree_d[s], hit_way);
            if (fill_we && fill_set == IDX_W'(s))
                tree_d[s] = touch(tree_d[s], fill_way);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
        end else begin
            for (int s = 0; s < SETS; s++) tree_q[s] <= tree_d[s];
        end
    end

    assign v_way = walk(tree_q[v_set]);

endmodule

// File: rtl/tagdir_top.sv
module tagdir_top
    import tagdir_pkg::*;
#(
    parameter int VADDR_W    = 32,
    parameter int PADDR_W    = 36,
    parameter int LINE_BYTES = 64,
    parameter int SETS       = 64,
    parameter int WAYS       = 8,
    parameter int PAGE_BYTES = 4096,
    parameter int ICACHE     = 0
) (
    input  logic                                              clk,
    input  logic                                              rst_n,
    input  logic                                              lk_valid,
    input  logic [VADDR_W-1:0]                                lk_vaddr,
    input  logic [PADDR_W-$clog2(PAGE_BYTES)-1:0]             lk_ptag,
    input  logic                                              op_valid,
    input  logic [1:0]                                        op_kind,
    input  logic [$clog2(SETS)-1:0]                           op_set,
    input  logic [$clog2(WAYS)-1:0]                           op_way,
    input  logic [PADDR_W-$clog2(PAGE_BYTES)-1:0]             op_tag,
    input  logic [1:0]                                        op_state,
    output logic                                              res_valid,
    output logic                                              res_hit,
    output logic [$clog2(WAYS)-1:0]                           res_way,
    output logic [1:0]                                        res_state,
    output logic                                              miss_req,
    output logic [PADDR_W-$clog2(PAGE_BYTES)+$clog2(SETS)-1:0] miss_line,
    output logic [$clog2(WAYS)-1:0]                           fill_way,
    output logic                                              wb_valid,
    output logic [PADDR_W-$clog2(PAGE_BYTES)-1:0]             wb_tag
);
    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int IDX_W = $clog2(SETS);
    localparam int WW    = $clog2(WAYS);
    localparam int PG_W  = $clog2(PAGE_BYTES);
    localparam int TAG_W = PADDR_W - PG_W;

    // ---------------- lookup sequencer ----------------
    lk_state_e        st_q, st_d;
    logic [IDX_W-1:0] idx_q;

    logic unused_va;
    assign unused_va = ^{lk_vaddr[VADDR_W-1:OFF_W+IDX_W], lk_vaddr[OFF_W-1:0]};

    always_comb begin
        unique case (st_q)
            LK_IDLE: st_d = lk_valid ? LK_CMP : LK_IDLE;
            LK_CMP:  st_d = lk_valid ? LK_CMP : LK_IDLE;
            default: st_d = LK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= LK_IDLE;
            idx_q <= '0;
        end else begin
            st_q <= st_d;
            if (lk_valid) idx_q <= lk_vaddr[OFF_W+IDX_W-1:OFF_W];
        end
    end

    // ---------------- operation decode ----------------
    logic is_fill, is_set, is_inv, we;
    assign is_fill = op_valid && (op_kind == OP_FILL);
    assign is_set  = op_valid && (op_kind == OP_SETST);
    assign is_inv  = op_valid && (op_kind == OP_INVAL);
    assign we      = is_fill || is_set || is_inv;

    function automatic logic [1:0] limit_state(logic [1:0] s);
        if (ICACHE != 0 && (s == MESI_E || s == MESI_M)) return MESI_S;
        return s;
    endfunction

    logic [1:0]       wr_state;
    logic [WW-1:0]    wr_way;
    logic [TAG_W-1:0] a_tag [WAYS];
    logic [1:0]       a_st  [WAYS];
    logic [TAG_W-1:0] b_tag [WAYS];
    logic [1:0]       b_st  [WAYS];
    logic [WW-1:0]    free_way, tree_way, vic_way;
    logic             any_free;

    assign wr_state = is_inv ? MESI_I : limit_state(op_state);

    always_comb begin
        any_free = 1'b0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (b_st[w] == MESI_I) begin
                any_free = 1'b1;
                free_way = WW'(w);
            end
        end
    end

    assign vic_way  = any_free ? free_way : tree_way;
    assign wr_way   = is_fill ? vic_way : op_way;
    assign fill_way = vic_way;
    assign wb_valid = is_fill && (b_st[vic_way] == MESI_M);
    assign wb_tag   = b_tag[vic_way];

    // ---------------- compare with forwarding ----------------
    logic [TAG_W-1:0] eff_tag [WAYS];
    logic [1:0]       eff_st  [WAYS];
    logic [WAYS-1:0]  hit_vec;
    logic [WW-1:0]    hit_way;

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            eff_tag[w] = a_tag[w];
            eff_st[w]  = a_st[w];
            if (we && op_set == idx_q && wr_way == WW'(w)) begin
                eff_st[w] = wr_state;
                if (is_fill) eff_tag[w] = op_tag;
            end
            hit_vec[w] = (eff_st[w] != MESI_I) && (eff_tag[w] == lk_ptag);
        end
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--)
            if (hit_vec[w]) hit_way = WW'(w);
    end

    always_comb begin
        res_valid = 1'b0;
        res_hit   = 1'b0;
        res_way   = '0;
        res_state = MESI_I;
        miss_req  = 1'b0;
        miss_line = '0;
        unique case (st_q)
            LK_IDLE: ;
            LK_CMP: begin
                res_valid = 1'b1;
                if (|hit_vec) begin
                    res_hit   = 1'b1;
                    res_way   = hit_way;
                    res_state = eff_st[hit_way];
                end else begin
                    miss_req  = 1'b1;
                    miss_line = {lk_ptag, idx_q};
                end
            end
            default: ;
        endcase
    end

    // ---------------- storage and replacement ----------------
    tagdir_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (we),
        .wr_set    (op_set),
        .wr_way    (wr_way),
        .wr_tag_en (is_fill),
        .wr_tag    (op_tag),
        .wr_state  (wr_state),
        .a_set     (idx_q),
        .a_tag     (a_tag),
        .a_st      (a_st),
        .b_set     (op_set),
        .b_tag     (b_tag),
        .b_st      (b_st)
    );

    tagdir_plru #(.SETS(SETS), .WAYS(WAYS)) u_plru (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit_we   (res_hit),
        .hit_set  (idx_q),
        .hit_way  (res_way),
        .fill_we  (is_fill),
        .fill_set (op_set),
        .fill_way (vic_way),
        .v_set    (op_set),
        .v_way    (tree_way)
    );

    // ---------------- assertions ----------------
    a_r3_result_after_lookup: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(lk_valid));

    a_r4_hit_not_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> res_state != MESI_I);

    a_r5_miss_only_on_result: assert property (@(posedge clk) disable iff (!rst_n)
        miss_req |-> (res_valid && !res_hit));

    a_r5_result_hit_or_miss: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_hit || miss_req));

    a_r6_free_way_first: assert property (@(posedge clk) disable iff (!rst_n)
        (is_fill && any_free) |-> b_st[fill_way] == MESI_I);

    a_r8_wb_only_on_fill: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (op_valid && op_kind == OP_FILL));

    if (ICACHE != 0) begin : g_icache_chk
        a_r11_icache_states: assert property (@(posedge clk) disable iff (!rst_n)
            res_hit |-> (res_state == MESI_S));
    end

endmodule

// File: tb/tagdir_top_bench.sv
`timescale 1ns/1ps
module tagdir_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [23:0] lk_ptag = '0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_kind = 2'b11;
    logic [5:0]  op_set = '0;
    logic [2:0]  op_way = '0;
    logic [23:0] op_tag = '0;
    logic [1:0]  op_state = '0;

    logic        res_valid, res_hit, miss_req, wb_valid;
    logic [2:0]  res_way, fill_way;
    logic [1:0]  res_state;
    logic [29:0] miss_line;
    logic [23:0] wb_tag;

    logic        ic_res_valid, ic_res_hit, ic_miss_req, ic_wb_valid;
    logic [2:0]  ic_res_way, ic_fill_way;
    logic [1:0]  ic_res_state;
    logic [29:0] ic_miss_line;
    logic [23:0] ic_wb_tag;

    always #10 clk = ~clk;

    tagdir_top u_tagdir_top (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_ptag(lk_ptag),
        .op_valid(op_valid), .op_kind(op_kind), .op_set(op_set), .op_way(op_way),
        .op_tag(op_tag), .op_state(op_state), .res_valid(res_valid), .res_hit(res_hit),
        .res_way(res_way), .res_state(res_state), .miss_req(miss_req), .miss_line(miss_line),
        .fill_way(fill_way), .wb_valid(wb_valid), .wb_tag(wb_tag));

    tagdir_top #(.ICACHE(1)) u_tagdir_top_ic (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_ptag(lk_ptag),
        .op_valid(op_valid), .op_kind(op_kind), .op_set(op_set), .op_way(op_way),
        .op_tag(op_tag), .op_state(op_state), .res_valid(ic_res_valid), .res_hit(ic_res_hit),
        .res_way(ic_res_way), .res_state(ic_res_state), .miss_req(ic_miss_req),
        .miss_line(ic_miss_line), .fill_way(ic_fill_way), .wb_valid(ic_wb_valid),
        .wb_tag(ic_wb_tag));

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    // directory model for the default (data) instance
    bit [23:0] m_tag  [64][8];
    bit [1:0]  m_st   [64][8];
    bit [6:0]  m_tree [64];

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit [6:0] m_touch(bit [6:0] t, bit [2:0] w);
        t[0] = ~w[2];
        t[1 + w[2]] = ~w[1];
        t[3 + 2 * w[2] + w[1]] = ~w[0];
        return t;
    endfunction

    function automatic bit [2:0] m_victim(int s);
        bit b0, b1, b2;
        for (int w = 0; w < 8; w++)
            if (m_st[s][w] == 2'b00) return 3'(w);
        b0 = m_tree[s][0];
        b1 = m_tree[s][1 + b0];
        b2 = m_tree[s][3 + 2 * b0 + b1];
        return {b0, b1, b2};
    endfunction

    function automatic bit [31:0] mk_va(int s);
        bit [31:0] v;
        v = $urandom;
        v[11:6] = 6'(s);
        return v;
    endfunction

    // compute expected result of a lookup against the model
    task automatic check_result(input int s, input bit [23:0] pt, input string req);
        bit h; bit [2:0] w;
        h = 0; w = 0;
        for (int k = 7; k >= 0; k--)
            if (m_st[s][k] != 2'b00 && m_tag[s][k] == pt) begin h = 1; w = 3'(k); end
        check(req, "res_valid", res_valid, 1);
        check(req, "res_hit", res_hit, h);
        check(req, "miss_req", miss_req, !h);
        check(req, "res_way", res_way, h ? w : 3'd0);
        check(req, "res_state", res_state, h ? m_st[s][w] : 2'b00);
        if (!h) check(req, "miss_line", miss_line, {pt, 6'(s)});
        if (h) m_tree[s] = m_touch(m_tree[s], w);
    endtask

    task automatic lookup(input bit [31:0] va, input bit [23:0] pt, input string req);
        @(negedge clk);
        op_valid = 0; lk_valid = 1; lk_vaddr = va;
        @(negedge clk);
        lk_valid = 0; lk_ptag = pt;
        #1;
        check_result(int'(va[11:6]), pt, req);
    endtask

    task automatic model_op(input bit [1:0] k, input int s, input bit [2:0] w,
                            input bit [23:0] t, input bit [1:0] st);
        bit [2:0] v;
        case (k)
            2'b00: begin
                v = m_victim(s);
                m_tag[s][v] = t; m_st[s][v] = st;
                m_tree[s] = m_touch(m_tree[s], v);
            end
            2'b01: m_st[s][w] = st;
            2'b10: m_st[s][w] = 2'b00;
            default: ;
        endcase
    endtask

    task automatic drive_op(input bit [1:0] k, input int s, input bit [2:0] w,
                            input bit [23:0] t, input bit [1:0] st);
        op_valid = 1; op_kind = k; op_set = 6'(s); op_way = w; op_tag = t; op_state = st;
    endtask

    task automatic do_op(input bit [1:0] k, input int s, input bit [2:0] w,
                         input bit [23:0] t, input bit [1:0] st, input string req);
        bit [2:0] v;
        @(negedge clk);
        lk_valid = 0;
        drive_op(k, s, w, t, st);
        #1;
        if (k == 2'b00) begin
            v = m_victim(s);
            check(req, "fill_way", fill_way, v);
            check("R8", "wb_valid", wb_valid, m_st[s][v] == 2'b11);
            if (m_st[s][v] == 2'b11) check("R8", "wb_tag", wb_tag, m_tag[s][v]);
        end else begin
            check("R8", "wb_valid on non-fill", wb_valid, 0);
        end
        model_op(k, s, w, t, st);
    endtask

    task automatic idle();
        @(negedge clk);
        op_valid = 0; lk_valid = 0;
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int seed_sink;
        seed_sink = $urandom(1234);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset state
        check("R1", "res_valid idle", res_valid, 0);
        check("R1", "miss_req idle", miss_req, 0);
        check("R1", "wb_valid idle", wb_valid, 0);
        lookup(mk_va(0), 24'h000000, "R1");
        lookup(mk_va(63), 24'h123456, "R1");
        do_op(2'b00, 17, 0, 24'h0a0a0a, 2'b10, "R1");
        check("R1", "first fill way", fill_way, 0);

        // R2: upper vaddr bits and offset ignored
        lookup({20'hfffff, 6'd17, 6'h3f}, 24'h0a0a0a, "R2");
        lookup({20'h00001, 6'd17, 6'h00}, 24'h0a0a0a, "R2");
        check("R2", "hit across aliases", res_hit, 1);
        lookup({20'h00001, 6'd18, 6'h00}, 24'h0a0a0a, "R2");
        check("R2", "other set misses", res_hit, 0);

        // R3: back-to-back lookups
        do_op(2'b00, 20, 0, 24'h000100, 2'b01, "R6");
        do_op(2'b00, 21, 0, 24'h000200, 2'b10, "R6");
        @(negedge clk);
        op_valid = 0; lk_valid = 1; lk_vaddr = mk_va(20);
        @(negedge clk);
        lk_vaddr = mk_va(21); lk_ptag = 24'h000100;
        #1;
        check_result(20, 24'h000100, "R3");
        check("R3", "first of pair hits", res_hit, 1);
        @(negedge clk);
        lk_valid = 0; lk_ptag = 24'h000200;
        #1;
        check_result(21, 24'h000200, "R3");
        check("R3", "second of pair state", res_state, 2'b10);

        // R7 and R8: full set, tree victim, Modified writeback
        for (int i = 0; i < 8; i++) do_op(2'b00, 30, 0, 24'h000300 + 24'(i), 2'b10, "R6");
        do_op(2'b01, 30, 0, 24'h0, 2'b11, "R9");
        do_op(2'b00, 30, 0, 24'h000399, 2'b01, "R7");
        check("R7", "tree victim after 0..7", fill_way, 0);
        check("R8", "wb flag", wb_valid, 1);
        check("R8", "wb tag", wb_tag, 24'h000300);
        do_op(2'b00, 30, 0, 24'h00039a, 2'b01, "R7");
        check("R7", "next tree victim", fill_way, 4);
        check("R8", "no wb for Exclusive victim", wb_valid, 0);
        lookup(mk_va(30), 24'h000399, "R7");

        // R9: set state, invalidate, ignored kind
        do_op(2'b00, 50, 0, 24'h005050, 2'b10, "R6");
        do_op(2'b11, 50, 0, 24'h0, 2'b00, "R9");
        lookup(mk_va(50), 24'h005050, "R9");
        check("R9", "kind 11 leaves line", res_state, 2'b10);
        do_op(2'b01, 50, 0, 24'h0, 2'b01, "R9");
        lookup(mk_va(50), 24'h005050, "R9");
        do_op(2'b10, 50, 0, 24'h0, 2'b00, "R9");
        lookup(mk_va(50), 24'h005050, "R9");
        check("R9", "invalidated misses", res_hit, 0);

        // R10: same-cycle operation forwarded into comparison
        do_op(2'b00, 10, 0, 24'h000abc, 2'b10, "R6");
        @(negedge clk);
        op_valid = 0; lk_valid = 1; lk_vaddr = mk_va(10);
        @(negedge clk);
        lk_valid = 0; lk_ptag = 24'h000abc;
        drive_op(2'b10, 10, 0, 24'h0, 2'b00);
        #1;
        model_op(2'b10, 10, 0, 24'h0, 2'b00);
        check_result(10, 24'h000abc, "R10");
        check("R10", "invalidate wins", res_hit, 0);
        @(negedge clk);
        op_valid = 0; lk_valid = 1; lk_vaddr = mk_va(11);
        @(negedge clk);
        lk_valid = 0; lk_ptag = 24'h000777;
        drive_op(2'b00, 11, 0, 24'h000777, 2'b01);
        #1;
        model_op(2'b00, 11, 0, 24'h000777, 2'b01);
        check_result(11, 24'h000777, "R10");
        check("R10", "fill forwarded hit", res_hit, 1);
        idle();

        // R11: instruction mode instance stores Shared only
        do_op(2'b00, 40, 0, 24'h000440, 2'b11, "R11");
        lookup(mk_va(40), 24'h000440, "R11");
        check("R11", "data mode keeps Modified", res_state, 2'b11);
        check("R11", "icache mode Shared", ic_res_state, 2'b01);
        do_op(2'b01, 40, 0, 24'h0, 2'b10, "R11");
        lookup(mk_va(40), 24'h000440, "R11");
        check("R11", "icache set-state Shared", ic_res_state, 2'b01);

        // random traffic on a few sets with a small tag pool (R4, R5, R6, R7, R8)
        for (int it = 0; it < 1500; it++) begin
            int r; int s; bit [23:0] t; bit [1:0] st; bit [2:0] w;
            r  = $urandom_range(0, 9);
            s  = $urandom_range(0, 3);
            t  = 24'($urandom_range(0, 5));
            st = 2'($urandom_range(1, 3));
            w  = 3'($urandom_range(0, 7));
            if (r < 4)       lookup(mk_va(s), t, "R4");
            else if (r < 7)  do_op(2'b00, s, w, t, st, "R7");
            else if (r == 7) do_op(2'b01, s, w, t, st, "R9");
            else if (r == 8) do_op(2'b10, s, w, t, st, "R9");
            else             do_op(2'b11, s, w, t, st, "R9");
        end
        for (int s = 0; s < 4; s++)
            for (int t = 0; t < 6; t++) lookup(mk_va(s), 24'(t), "R5");
        idle();

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule